// File: doc/BRIEF.md
# Transmit Start Gate

This block decides the cycle in which a MAC may begin sending the preamble of the frame it has queued. It watches two things: how many bytes of the current frame are in the MAC transmit FIFO, and whether the DMA side has reported that the whole frame has been fetched from host memory. A 2-bit start-point code sets the minimum FIFO occupancy. A hold-for-complete-frame option can also require the DMA end-of-frame report before starting. This option prevents underflow when parts of the frame still sit in the bus FIFO or in buffer memory.

The block produces one single-cycle permission pulse per frame. It then waits for the MAC to report that transmission has ended before it can issue the next permission. An end-of-frame report from DMA is held in the block until the permission it qualifies has been issued. A report that arrives during a transmission is therefore credited to the next frame.

Top module: `tx_start_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tx_start` is low. The gate comes out of reset armed, with no DMA end-of-frame held.
- R2: With `cfg_hold_full` low and `cfg_start_code` equal to 0, 1 or 2, a start is allowed once `fifo_bytes` is at least 4, 64 or 128 respectively. `tx_start` rises in the cycle after the first cycle in which the armed gate sees the condition met.
- R3: With `cfg_hold_full` low and codes 0 to 2, no start is issued while `fifo_bytes` is below the threshold and `fifo_has_eof` is low.
- R4: With `cfg_hold_full` low and code 3 (full frame), a start is allowed only when `fifo_has_eof` is high, whatever the value of `fifo_bytes`.
- R5: With codes 0 to 2, `fifo_has_eof` high counts as meeting the threshold. This lets a frame shorter than the threshold start.
- R6: With `cfg_hold_full` high and codes 0 to 2, a start needs both the threshold condition of R2/R5 and a DMA end-of-frame for the frame. The end-of-frame may be held from earlier or be pulsing on `dma_frame_done` in the same cycle.
- R7: With `cfg_hold_full` high and code 3, the occupancy condition is ignored, and the DMA end-of-frame alone allows the start.
- R8: A `dma_frame_done` pulse is held until a start is issued, so a start can be allowed later by occupancy alone.
- R9: `tx_start` is a one-cycle pulse, and at most one is issued per frame.
- R10: After a start, no further start is issued until `mac_tx_end` has been seen. The gate rearms in the cycle after `mac_tx_end`.
- R11: A `dma_frame_done` pulse that arrives while a frame is being transmitted is held and qualifies the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_code | input | 2 | Start-point code: 0=4 bytes, 1=64, 2=128, 3=full frame |
| cfg_hold_full | input | 1 | Also require the DMA end-of-frame before starting |
| fifo_bytes | input | LEVEL_W (12) | Bytes of the current frame in the MAC transmit FIFO |
| fifo_has_eof | input | 1 | The frame's last byte is in the MAC transmit FIFO |
| dma_frame_done | input | 1 | One-cycle pulse: DMA has moved the whole frame in |
| mac_tx_end | input | 1 | One-cycle pulse: MAC finished sending the frame |
| tx_start | output | 1 | One-cycle permission to start the preamble |

## Verification
The assertions assume that the start code and the hold option stay steady while a frame waits for its permission. They also assume that `mac_tx_end` and `dma_frame_done` are single-cycle pulses and that `fifo_bytes` describes the frame now queued. The directed cases change the configuration only between frames. The random phase draws a new code and option only occasionally, and it keeps the occupancy within 0 to 255 so that every threshold is crossed in both directions. The bench's cycle model applies whatever configuration is present in each cycle, so a configuration change in the random phase does not break its expected values.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        SP_LOW  = 2'd0,
        SP_MID  = 2'd1,
        SP_HIGH = 2'd2,
        SP_FULL = 2'd3
    } start_code_e;

    typedef enum logic {
        SEQ_ARMED  = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic thr_met;
        logic eof_seen;
        logic gate;
    } gate_info_t;

    // Combine occupancy and DMA completion according to the hold option.
    function automatic logic gate_ok(input logic hold, input logic thr_met,
                                     input logic eof_seen);
        return hold ? (thr_met && eof_seen) : thr_met;
    endfunction

endpackage

// File: rtl/tsg_threshold.sv
module tsg_threshold
    import tsg_pkg::*;
#(
    parameter int LEVEL_W = 12,
    parameter int TH0     = 4,
    parameter int TH1     = 64,
    parameter int TH2     = 128
) (
    input  start_code_e          code,
    input  logic                 hold,
    input  logic [LEVEL_W-1:0]   level,
    input  logic                 has_eof,
    output logic                 thr_met
);
    localparam int NUM_TH = 3;
    localparam int TH_TAB [NUM_TH] = '{TH0, TH1, TH2};

    logic [NUM_TH-1:0] hit;

    for (genvar g = 0; g < NUM_TH; g++) begin : g_cmp
        assign hit[g] = (32'(level) >= 32'(TH_TAB[g]));
    end

    always_comb begin
        unique case (code)
            SP_LOW:  thr_met = hit[0] | has_eof;
            SP_MID:  thr_met = hit[1] | has_eof;
            SP_HIGH: thr_met = hit[2] | has_eof;
            SP_FULL: thr_met = hold ? 1'b1 : has_eof;
            default: thr_met = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsg_eof_latch.sv
module tsg_eof_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic consume,
    output logic seen
);
    logic held_q;

    assign seen = held_q | set_pulse;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= seen & ~consume;
    end
endmodule

// File: rtl/tsg_sequencer.sv
module tsg_sequencer
    import tsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic gate,
    input  logic tx_end,
    output logic fire,
    output logic start_q
);
    seq_state_e state_q, state_d;

    assign fire = (state_q == SEQ_ARMED) && gate;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_ARMED:  if (fire)   state_d = SEQ_ACTIVE;
            SEQ_ACTIVE: if (tx_end) state_d = SEQ_ARMED;
            default:                state_d = SEQ_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_ARMED;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= fire;
        end
    end
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
    import tsg_pkg::*;
#(
    parameter int LEVEL_W = 12,
    parameter int TH0     = 4,
    parameter int TH1     = 64,
    parameter int TH2     = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_start_code,
    input  logic               cfg_hold_full,
    input  logic [LEVEL_W-1:0] fifo_bytes,
    input  logic               fifo_has_eof,
    input  logic               dma_frame_done,
    input  logic               mac_tx_end,
    output logic               tx_start
);
    gate_info_t info;
    logic       fire;

    tsg_threshold #(
        .LEVEL_W(LEVEL_W), .TH0(TH0), .TH1(TH1), .TH2(TH2)
    ) u_thr (
        .code    (start_code_e'(cfg_start_code)),
        .hold    (cfg_hold_full),
        .level   (fifo_bytes),
        .has_eof (fifo_has_eof),
        .thr_met (info.thr_met)
    );

    tsg_eof_latch u_eof (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (dma_frame_done),
        .consume   (fire),
        .seen      (info.eof_seen)
    );

    assign info.gate = gate_ok(cfg_hold_full, info.thr_met, info.eof_seen);

    tsg_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .gate    (info.gate),
        .tx_end  (mac_tx_end),
        .fire    (fire),
        .start_q (tx_start)
    );
endmodule

// File: rtl/tx_start_gate_chk.sv
module tx_start_gate_chk #(
    parameter int LEVEL_W = 12,
    parameter int TH0     = 4,
    parameter int TH1     = 64,
    parameter int TH2     = 128
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         cfg_start_code,
    input logic               cfg_hold_full,
    input logic [LEVEL_W-1:0] fifo_bytes,
    input logic               fifo_has_eof,
    input logic               mac_tx_end,
    input logic               tx_start
);
    function automatic int thr_of(input logic [1:0] c);
        return (c == 2'd0) ? TH0 : (c == 2'd1) ? TH1 : TH2;
    endfunction

    // Set by a permission, cleared by the end-of-transmission report.
    logic in_flight;
    always_ff @(posedge clk) begin
        if (rst) in_flight <= 1'b0;
        else     in_flight <= (in_flight | tx_start) & ~mac_tx_end;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !tx_start);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    // R10
    rearm_needed_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !in_flight);

    // R3
    threshold_met_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !$past(cfg_hold_full) && $past(cfg_start_code) != 2'd3)
        |-> ($past(fifo_has_eof) || 32'($past(fifo_bytes)) >= 32'(thr_of($past(cfg_start_code)))));

    // R4
    full_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !$past(cfg_hold_full) && $past(cfg_start_code) == 2'd3)
        |-> $past(fifo_has_eof));
endmodule

bind tx_start_gate tx_start_gate_chk #(
    .LEVEL_W(LEVEL_W), .TH0(TH0), .TH1(TH1), .TH2(TH2)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_start_code (cfg_start_code),
    .cfg_hold_full  (cfg_hold_full),
    .fifo_bytes     (fifo_bytes),
    .fifo_has_eof   (fifo_has_eof),
    .mac_tx_end     (mac_tx_end),
    .tx_start       (tx_start)
);

// File: tb/tx_start_gate_test.sv
module tx_start_gate_test;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    code = 2'd0;
    logic          hold = 1'b0;
    logic [LW-1:0] bytes = '0;
    logic          has_eof = 1'b0;
    logic          dma = 1'b0;
    logic          tx_end = 1'b0;
    logic          tx_start;

    int    checks = 0;
    int    errors = 0;
    int    n_starts = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Cycle model state.
    bit m_armed = 1'b1;
    bit m_latch = 1'b0;
    bit m_start = 1'b0;

    always #4 clk = ~clk;

    tx_start_gate #(.LEVEL_W(LW)) uut (
        .clk(clk), .rst(rst), .cfg_start_code(code), .cfg_hold_full(hold),
        .fifo_bytes(bytes), .fifo_has_eof(has_eof), .dma_frame_done(dma),
        .mac_tx_end(tx_end), .tx_start(tx_start)
    );

    function automatic int req_thr(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 64 : 128;
    endfunction

    function automatic bit occupancy_ok(input logic [1:0] c, input bit h,
                                        input int lvl, input bit eof);
        if (c == 2'd3) return h ? 1'b1 : eof;
        return (lvl >= req_thr(c)) || eof;
    endfunction

    always @(posedge clk) begin
        bit seen, gate, fire;
        cyc++;
        if (tx_start) n_starts++;
        if (rst) begin
            m_armed <= 1'b1; m_latch <= 1'b0; m_start <= 1'b0;
        end else begin
            seen = m_latch || dma;
            gate = occupancy_ok(code, hold, int'(bytes), has_eof) && (!hold || seen);
            fire = m_armed && gate;
            m_start <= fire;
            m_latch <= seen && !fire;
            if (fire) m_armed <= 1'b0;
            else if (!m_armed && tx_end) m_armed <= 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (tx_start !== m_start) begin
                errors++;
                $display("FAIL %s: tx_start=%0b expected %0b at cycle %0d",
                         cur_req, tx_start, m_start, cyc);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc >= 100000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog (all requirements): cycle=%0d expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_dma();
        dma = 1'b1; step(1); dma = 1'b0;
    endtask

    task automatic end_frame();
        bytes = '0; has_eof = 1'b0;
        tx_end = 1'b1; step(1); tx_end = 1'b0;
        step(2);
    endtask

    task automatic expect_starts(input string req, input int base, input int exp);
        step(2);
        checks++;
        if (n_starts - base != exp) begin
            errors++;
            $display("FAIL %s: starts=%0d expected %0d", req, n_starts - base, exp);
        end
    endtask

    initial begin
        int base;
        void'($urandom(32'h5eed_1234));
        step(3);
        // R1: quiet during and right after reset
        checks++;
        if (tx_start !== 1'b0) begin
            errors++; $display("FAIL R1: tx_start=%0b expected 0", tx_start);
        end
        rst = 1'b0;
        step(1);
        checks++;
        if (tx_start !== 1'b0) begin
            errors++; $display("FAIL R1: tx_start=%0b expected 0 after reset", tx_start);
        end

        // R2: code 1 starts at 64 bytes
        cur_req = "R2"; code = 2'd1; hold = 1'b0; base = n_starts;
        for (int b = 60; b < 64; b++) begin bytes = LW'(b); step(1); end
        expect_starts("R2", base, 0);
        bytes = 12'd64; step(3);
        expect_starts("R2", base, 1);
        end_frame();

        // R3: code 2 held just below 128
        cur_req = "R3"; code = 2'd2; base = n_starts;
        bytes = 12'd127; step(20);
        expect_starts("R3", base, 0);
        bytes = '0; step(1);

        // R4: full-frame code ignores occupancy
        cur_req = "R4"; code = 2'd3; base = n_starts;
        bytes = 12'd1000; step(10);
        expect_starts("R4", base, 0);
        has_eof = 1'b1; step(3);
        expect_starts("R4", base, 1);
        end_frame();

        // R5: short frame below threshold
        cur_req = "R5"; code = 2'd2; base = n_starts;
        bytes = 12'd20; has_eof = 1'b1; step(3);
        expect_starts("R5", base, 1);
        end_frame();

        // R6: hold option needs DMA completion
        cur_req = "R6"; hold = 1'b1; code = 2'd0; base = n_starts;
        bytes = 12'd100; step(10);
        expect_starts("R6", base, 0);
        pulse_dma(); step(2);
        expect_starts("R6", base, 1);
        end_frame();

        // R8: completion held until occupancy arrives
        cur_req = "R8"; base = n_starts;
        pulse_dma(); step(10);
        expect_starts("R8", base, 0);
        bytes = 12'd10; step(3);
        expect_starts("R8", base, 1);
        end_frame();

        // R7: hold with full-frame code, empty FIFO
        cur_req = "R7"; code = 2'd3; base = n_starts;
        step(5);
        expect_starts("R7", base, 0);
        pulse_dma(); step(2);
        expect_starts("R7", base, 1);
        end_frame();

        // R10: no second start until end of transmission
        cur_req = "R10"; hold = 1'b0; code = 2'd0; base = n_starts;
        bytes = 12'd50; step(20);
        expect_starts("R10", base, 1);
        tx_end = 1'b1; step(1); tx_end = 1'b0; step(3);
        expect_starts("R10", base, 2);
        end_frame();

        // R11: completion during transmission qualifies the next frame
        cur_req = "R11"; hold = 1'b1; code = 2'd1; base = n_starts;
        bytes = 12'd64; pulse_dma(); step(2);
        expect_starts("R11", base, 1);
        pulse_dma(); step(1);
        end_frame(); step(3);
        expect_starts("R11", base, 1);
        bytes = 12'd64; step(3);
        expect_starts("R11", base, 2);
        end_frame();

        // R9: random traffic against the cycle model
        cur_req = "R9";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) begin
                code = 2'($urandom_range(0, 3));
                hold = 1'($urandom_range(0, 1));
            end
            bytes   = LW'($urandom_range(0, 255));
            has_eof = ($urandom_range(0, 7) == 0);
            dma     = ($urandom_range(0, 15) == 0);
            tx_end  = ($urandom_range(0, 19) == 0);
            step(1);
        end
        dma = 1'b0; tx_end = 1'b0; has_eof = 1'b0; bytes = '0;
        step(3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule